// File: doc/BRIEF.md
# External Bus Address-Phase Drive Controller

This block decides, for every half phase of an external bus cycle, whether the 16-bit multiplexed address/data bus is driven and with which value. It also drives a separate 20-bit address bus. The separate address bus carries the address for the whole cycle and becomes valid half a phase before the address appears on the multiplexed bus. Time is counted in half phases: each bus phase T1 to T4 spans two clocks, marked by `half` = 0 and then `half` = 1.

Two memory regions, upper and lower, each have a mute bit. A set mute bit keeps the address off the multiplexed bus for accesses to that region, and the bus floats instead. This reduces switching on the bus. A strap pin is captured while reset is high and its value at reset release is kept until the next reset. When the captured strap is 1, both mute bits are ignored so that the bus always carries the address.

All outputs are registered. Each output reflects the inputs of the previous clock.

Top module: `bus_adp_ctrl`

## Requirements
- R1: While `rst` is high, on the following clock `ad_oe`, `a_oe`, `ad_out` and `a_out` are all 0.
- R2: `keep_strap` is captured on every clock with `rst` high and held afterwards. Changes of the pin after reset release have no effect on the drive decision.
- R3: One clock after each active half phase, `a_oe` is 1. `a_out` takes `addr` from the clock with `cyc_act`=1, `ph`=0 (T1) and `half`=0, and holds that value until the next such clock.
- R4: In T1 with `half`=1, when the address is not muted, `ad_oe` is 1 and `ad_out` equals the low 16 bits of the captured address on the next clock. This is one clock later than the address appears on `a_out`.
- R5: In T1 with `half`=0, `ad_oe` is 0 and `ad_out` is 0 on the next clock.
- R6: `region`=1 (upper) with `up_mute`=1 and a captured strap of 0 floats the multiplexed bus (`ad_oe`=0, `ad_out`=0) for the T1 `half`=1 slot.
- R7: `region`=2 (lower) with `lo_mute`=1 and a captured strap of 0 floats the multiplexed bus for the T1 `half`=1 slot.
- R8: `region` 0 or 3 (outside both regions) always drives the address in the T1 `half`=1 slot, whatever the mute bits are.
- R9: With a captured strap of 1, the address is driven in the T1 `half`=1 slot for every region and every setting of the mute bits.
- R10: In T2 to T4 (`ph`=1,2,3) with `is_write`=1, `ad_oe` is 1 and `ad_out` equals `wdata` on the next clock.
- R11: In T2 to T4 with `is_write`=0, `ad_oe` is 0 and `ad_out` is 0 on the next clock.
- R12: With `cyc_act`=0, `ad_oe`, `a_oe` and `ad_out` are 0 on the next clock, and `a_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one per half phase |
| rst | input | 1 | Synchronous active-high reset |
| keep_strap | input | 1 | Strap that forces address drive, captured during reset |
| up_mute | input | 1 | Mute bit for the upper region |
| lo_mute | input | 1 | Mute bit for the lower region |
| cyc_act | input | 1 | A bus cycle is in progress |
| ph | input | 2 | Phase: 0=T1, 1=T2, 2=T3, 3=T4 |
| half | input | 1 | 0 first half, 1 second half of the phase |
| is_write | input | 1 | Current cycle is a write |
| region | input | 2 | 0 other, 1 upper, 2 lower, 3 other |
| addr | input | 20 | Cycle address |
| wdata | input | 16 | Write data |
| ad_oe | output | 1 | Drive enable of the multiplexed bus |
| ad_out | output | 16 | Value for the multiplexed bus (0 when floating) |
| a_oe | output | 1 | Drive enable of the address bus |
| a_out | output | 20 | Value for the address bus |

## Verification
Every result is due exactly one clock after the half phase that causes it. The multiplexed bus address therefore appears one clock after `a_out` has taken that same address. The bench drives inputs on the falling edge and computes the expected outputs for the next rising edge from its own model of the requirements. It compares all four outputs on the falling edge after that rising edge, on every clock. The strap check holds the pin at a value that contradicts the captured value while muted cycles run, so the effect of the captured value is seen directly on the bus outputs.

// File: rtl/bus_adp_pkg.sv
package bus_adp_pkg;
  typedef enum logic [1:0] {
    RG_OTHER = 2'd0,
    RG_UPPER = 2'd1,
    RG_LOWER = 2'd2,
    RG_SPARE = 2'd3
  } region_t;

  typedef enum logic [1:0] {
    PH_T1 = 2'd0,
    PH_T2 = 2'd1,
    PH_T3 = 2'd2,
    PH_T4 = 2'd3
  } phase_t;
endpackage

// File: rtl/adp_strap_latch.sv
module adp_strap_latch (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic keep_q
);
  always_ff @(posedge clk) begin
    if (rst) keep_q <= pin;
  end

  assert_strap_hold_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(keep_q));
endmodule

// File: rtl/adp_addr_track.sv
module adp_addr_track
  import bus_adp_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_act,
  input  phase_t        ph,
  input  logic          half,
  input  logic [AW-1:0] addr,
  input  region_t       region,
  output logic          a_oe,
  output logic [AW-1:0] a_out,
  output region_t       lat_region
);
  logic start_slot;
  assign start_slot = cyc_act && (ph == PH_T1) && !half;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_oe       <= 1'b0;
      a_out      <= '0;
      lat_region <= RG_OTHER;
    end else begin
      a_oe <= cyc_act;
      if (start_slot) begin
        a_out      <= addr;
        lat_region <= region;
      end
    end
  end

  assert_abus_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !start_slot |=> $stable(a_out));
  assert_abus_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !cyc_act |=> !a_oe);
endmodule

// File: rtl/adp_ad_drive.sv
module adp_ad_drive
  import bus_adp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_act,
  input  phase_t        ph,
  input  logic          half,
  input  logic          is_write,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] lat_addr,
  input  region_t       lat_region,
  input  logic          up_mute,
  input  logic          lo_mute,
  input  logic          keep_q,
  output logic          ad_oe,
  output logic [DW-1:0] ad_out
);
  logic muted;
  logic nxt_oe;
  logic [DW-1:0] nxt_val;

  always_comb begin
    unique case (lat_region)
      RG_UPPER: muted = up_mute;
      RG_LOWER: muted = lo_mute;
      default:  muted = 1'b0;
    endcase
    if (keep_q) muted = 1'b0;
  end

  always_comb begin
    nxt_oe  = 1'b0;
    nxt_val = '0;
    if (cyc_act) begin
      if (ph == PH_T1) begin
        if (half && !muted) begin
          nxt_oe  = 1'b1;
          nxt_val = lat_addr;
        end
      end else if (is_write) begin
        nxt_oe  = 1'b1;
        nxt_val = wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_oe  <= 1'b0;
      ad_out <= '0;
    end else begin
      ad_oe  <= nxt_oe;
      ad_out <= nxt_val;
    end
  end

  assert_t1_early_float_R5: assert property (@(posedge clk) disable iff (rst)
    (cyc_act && ph == PH_T1 && !half) |=> !ad_oe);
  assert_read_float_R11: assert property (@(posedge clk) disable iff (rst)
    (cyc_act && ph != PH_T1 && !is_write) |=> !ad_oe);
  assert_ad_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !cyc_act |=> (!ad_oe && ad_out == '0));
  assert_write_drive_R10: assert property (@(posedge clk) disable iff (rst)
    (cyc_act && ph != PH_T1 && is_write) |=> (ad_oe && ad_out == $past(wdata)));
endmodule

// File: rtl/bus_adp_ctrl.sv
module bus_adp_ctrl
  import bus_adp_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          keep_strap,
  input  logic          up_mute,
  input  logic          lo_mute,
  input  logic          cyc_act,
  input  logic [1:0]    ph,
  input  logic          half,
  input  logic          is_write,
  input  logic [1:0]    region,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ad_oe,
  output logic [DW-1:0] ad_out,
  output logic          a_oe,
  output logic [AW-1:0] a_out
);
  localparam int LOW_W = (DW < AW) ? DW : AW;

  logic          keep_q;
  region_t       lat_region;
  logic [DW-1:0] lat_low;

  generate
    if (DW > AW) begin : g_pad
      assign lat_low = {{(DW-AW){1'b0}}, a_out};
    end else begin : g_cut
      assign lat_low = a_out[LOW_W-1:0];
    end
  endgenerate

  adp_strap_latch u_strap (
    .clk    (clk),
    .rst    (rst),
    .pin    (keep_strap),
    .keep_q (keep_q)
  );

  adp_addr_track #(.AW(AW)) u_track (
    .clk        (clk),
    .rst        (rst),
    .cyc_act    (cyc_act),
    .ph         (phase_t'(ph)),
    .half       (half),
    .addr       (addr),
    .region     (region_t'(region)),
    .a_oe       (a_oe),
    .a_out      (a_out),
    .lat_region (lat_region)
  );

  adp_ad_drive #(.DW(DW)) u_drive (
    .clk        (clk),
    .rst        (rst),
    .cyc_act    (cyc_act),
    .ph         (phase_t'(ph)),
    .half       (half),
    .is_write   (is_write),
    .wdata      (wdata),
    .lat_addr   (lat_low),
    .lat_region (lat_region),
    .up_mute    (up_mute),
    .lo_mute    (lo_mute),
    .keep_q     (keep_q),
    .ad_oe      (ad_oe),
    .ad_out     (ad_out)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ad_oe && !a_oe && ad_out == '0 && a_out == '0));
  assert_lead_R4: assert property (@(posedge clk) disable iff (rst)
    (cyc_act && ph == 2'd0 && half && ad_oe == 1'b0 && a_oe) |=>
      (!ad_oe || ad_out == $past(lat_low)));
endmodule

// File: tb/sim_bus_adp_ctrl.sv
module sim_bus_adp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic keep_strap = 1'b0;
  logic up_mute = 1'b0;
  logic lo_mute = 1'b0;
  logic cyc_act = 1'b0;
  logic [1:0] ph = 2'd0;
  logic half = 1'b0;
  logic is_write = 1'b0;
  logic [1:0] region = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ad_oe;
  logic [DW-1:0] ad_out;
  logic a_oe;
  logic [AW-1:0] a_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model state
  bit m_keep = 1'b0;
  bit [AW-1:0] m_a = '0;
  int m_reg = 0;
  bit e_ad_oe, e_a_oe;
  bit [DW-1:0] e_ad;
  bit [AW-1:0] e_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_adp_ctrl #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .keep_strap(keep_strap), .up_mute(up_mute),
    .lo_mute(lo_mute), .cyc_act(cyc_act), .ph(ph), .half(half),
    .is_write(is_write), .region(region), .addr(addr), .wdata(wdata),
    .ad_oe(ad_oe), .ad_out(ad_out), .a_oe(a_oe), .a_out(a_out)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // predict outputs after the next rising edge, then compare on the falling edge
  task automatic tick(input string tag);
    bit mute;
    if (rst) begin
      m_keep = keep_strap;
      m_a = '0; m_reg = 0;
      e_ad_oe = 0; e_ad = '0; e_a_oe = 0; e_a = '0;
    end else begin
      e_a_oe = cyc_act;
      e_ad_oe = 0; e_ad = '0;
      if (cyc_act) begin
        if (ph == 2'd0) begin
          if (half) begin
            mute = !m_keep && ((m_reg == 1 && up_mute) || (m_reg == 2 && lo_mute));
            if (!mute) begin e_ad_oe = 1; e_ad = m_a[DW-1:0]; end
          end else begin
            m_a = addr; m_reg = region;
          end
        end else if (is_write) begin
          e_ad_oe = 1; e_ad = wdata;
        end
      end
      e_a = m_a;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "ad_oe", ad_oe, e_ad_oe);
    chk(tag, "ad_out", ad_out, e_ad);
    chk(tag, "a_oe", a_oe, e_a_oe);
    chk(tag, "a_out", a_out, e_a);
  endtask

  task automatic bus_cycle(input logic [1:0] rg, input logic [AW-1:0] ad,
                           input logic [DW-1:0] wd, input bit wr, input string tag);
    cyc_act = 1; region = rg; addr = ad; is_write = wr;
    for (int p = 0; p < 4; p++) begin
      for (int h = 0; h < 2; h++) begin
        ph = p[1:0]; half = h[0];
        wdata = wd + DW'(p * 2 + h);
        tick(tag);
      end
    end
    cyc_act = 0;
    addr = ~ad;
    tick("R12");
  endtask

  initial begin
    @(negedge clk);
    rst = 1; keep_strap = 0;
    tick("R1"); tick("R1");
    rst = 0;
    keep_strap = 1;            // R2: late change must not matter
    tick("R12");
    up_mute = 1; lo_mute = 1;
    bus_cycle(2'd1, 20'hA1234, 16'h5000, 1'b0, "R6");
    bus_cycle(2'd2, 20'hB5678, 16'h6000, 1'b1, "R7");
    bus_cycle(2'd0, 20'hC9ABC, 16'h7000, 1'b1, "R8");
    bus_cycle(2'd3, 20'hD0F0F, 16'h7100, 1'b0, "R8");
    bus_cycle(2'd1, 20'h11111, 16'h7200, 1'b1, "R2");
    up_mute = 0; lo_mute = 1;
    bus_cycle(2'd1, 20'hE2468, 16'h8000, 1'b1, "R4");
    bus_cycle(2'd1, 20'h3ACE1, 16'h8100, 1'b0, "R11");
    up_mute = 1; lo_mute = 0;
    bus_cycle(2'd2, 20'hF1357, 16'h9000, 1'b1, "R10");
    bus_cycle(2'd2, 20'h2BDF0, 16'h9100, 1'b0, "R3");
    // second reset with strap captured high
    rst = 1; keep_strap = 1;
    tick("R1"); tick("R1");
    rst = 0; keep_strap = 0;
    up_mute = 1; lo_mute = 1;
    bus_cycle(2'd1, 20'h4C0DE, 16'hA000, 1'b0, "R9");
    bus_cycle(2'd2, 20'h5BEEF, 16'hB000, 1'b1, "R9");
    bus_cycle(2'd0, 20'h6FACE, 16'hC000, 1'b0, "R5");
    tick("R12"); tick("R12");
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule